// File: doc/BRIEF.md
# Integer-N Frequency Synthesizer Digital Core

This block is the digital part of an integer-N phase-locked loop. A fixed counter divides the crystal clock down to the comparison frequency. A programmable counter divides the VCO clock by a ratio N. A phase/frequency detector compares the falling edges of the two divided signals. Its outputs drive the source and sink enables of an external charge pump, together with a current-level select. A three-bit test code can put either divided signal on the detector pin, or switch the detector pin (and, in one code, the loop amplifier output as well) to high impedance.

Both crystal and VCO signals arrive as plain inputs and are oversampled by the block clock `clk`, which must run well above either of them. Each input passes through a synchronizer and a rising-edge detector that feed its counter. The detector is fully synchronous to `clk`. A pump output therefore stays active for whole `clk` cycles: the number of cycles between the two divided falling edges. The ratio, boost bit and test code are plain control inputs, expected to come from a control register. The block has no streaming interface, so there is no valid/ready handshake.

Top module: `fsyn_core`

## Requirements
- R1: During and right after the active-high synchronous reset, with test code 000, `up_en`, `dn_en` and `pin_oe` are 0 and `amp_oe` is 1.
- R2: The reference counter divides the crystal input by `REF_DIV`. The divided reference signal falls once every `REF_DIV` crystal periods.
- R3: If the divided VCO signal falls before the divided reference, `up_en` is high for exactly as many `clk` cycles as lie between the two falls, and `dn_en` stays low.
- R4: If the divided reference signal falls first, `dn_en` is high for exactly the number of `clk` cycles between the two falls, and `up_en` stays low.
- R5: If both divided signals fall in the same cycle, neither pump enable is raised and the detector pin remains undriven.
- R6: The VCO ratio is `{1'b1, n_word[NW-2:0]}`, which covers 2^(NW-1) to 2^NW-1. The most significant bit of `n_word` has no effect.
- R7: A change of `n_word` in the middle of a divided-VCO period leaves that period at the old ratio. The new ratio applies from the next terminal count.
- R8: `cur_hi` (1 = 5x pump current, 0 = 1x) follows `boost`.
- R9: With test code 100, `pin_oe` is 1 and `pin_val` carries the divided reference. With 110, they carry the divided VCO signal. In both codes the pump enables are 0.
- R10: With test code 111, the detector pin and the pump enables are off while `amp_oe` stays 1. With 011, `amp_oe` is also 0. Any unlisted code behaves like 000, where `pin_oe = up_en | dn_en` and `pin_val = up_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling block clock |
| rst | input | 1 | Synchronous reset, active high |
| xtal_in | input | 1 | Crystal oscillator signal |
| vco_in | input | 1 | VCO signal |
| n_word | input | NW | Divider ratio word |
| boost | input | 1 | Pump current select, 1 = 5x |
| tmode | input | 3 | Test code |
| up_en | output | 1 | Charge-pump source enable |
| dn_en | output | 1 | Charge-pump sink enable |
| cur_hi | output | 1 | Pump current level select |
| pin_oe | output | 1 | Detector pin drive enable |
| pin_val | output | 1 | Detector pin level when driven |
| amp_oe | output | 1 | Loop amplifier output enable |

## Verification
The bench builds the core with `REF_DIV` = 5 and `NW` = 4. This gives eight reachable ratios (8 to 15), and a comparison period of only a few dozen cycles. With these values the bench sweeps all sixteen ratio words at two VCO periods. The sweep covers leading, lagging and coincident edges, and each measured pulse width is checked against the product of count and period. The short periods also make it cheap to measure several whole divided periods on the test pin, which brings the deferred ratio update and every test code within reach.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;
  typedef enum logic [2:0] {
    TM_NORMAL = 3'b000,
    TM_REF    = 3'b100,
    TM_VCO    = 3'b110,
    TM_PD_Z   = 3'b111,
    TM_ALL_Z  = 3'b011
  } tmode_e;
endpackage

// File: rtl/fsyn_div.sv
module fsyn_div #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sig_in,
  input  logic [W-1:0] ratio,
  output logic         div_o,
  output logic         fall_o
);
  logic [2:0]   sy;
  logic [W-1:0] cnt, cnt_nx, ratio_q;
  logic         rise, last, wrap;

  always_ff @(posedge clk) begin
    if (rst) sy <= '0;
    else     sy <= {sy[1:0], sig_in};
  end

  assign rise = sy[1] & ~sy[2];
  assign last = (cnt == ratio_q - 1'b1);
  assign wrap = rise & last;

  always_comb begin
    cnt_nx = cnt;
    if (rise) cnt_nx = last ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ratio_q <= ratio;
      div_o   <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
      div_o  <= (cnt_nx >= (ratio_q >> 1));
      fall_o <= wrap;
      if (wrap) ratio_q <= ratio;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < ratio_q); // R6
  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(ratio_q)); // R7
  AST_FALL_LOW: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> !div_o); // R2
endmodule

// File: rtl/fsyn_pfd.sv
module fsyn_pfd (
  input  logic clk,
  input  logic rst,
  input  logic ref_fall,
  input  logic vco_fall,
  output logic up_o,
  output logic dn_o
);
  logic up_n, dn_n;

  assign up_n = up_o | vco_fall;
  assign dn_n = dn_o | ref_fall;

  always_ff @(posedge clk) begin
    if (rst || (up_n && dn_n)) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= up_n;
      dn_o <= dn_n;
    end
  end

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(up_o && dn_o)); // R3
  AST_VCO_LEADS: assert property (@(posedge clk) disable iff (rst)
    (vco_fall && !ref_fall && !dn_o) |=> up_o); // R3
  AST_REF_LEADS: assert property (@(posedge clk) disable iff (rst)
    (ref_fall && !vco_fall && !up_o) |=> dn_o); // R4
  AST_COINCIDE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ref_fall && vco_fall && !up_o && !dn_o) |=> (!up_o && !dn_o)); // R5
endmodule

// File: rtl/fsyn_core.sv
module fsyn_core #(
  parameter int REF_DIV = 400,
  parameter int NW      = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xtal_in,
  input  logic          vco_in,
  input  logic [NW-1:0] n_word,
  input  logic          boost,
  input  logic [2:0]    tmode,
  output logic          up_en,
  output logic          dn_en,
  output logic          cur_hi,
  output logic          pin_oe,
  output logic          pin_val,
  output logic          amp_oe
);
  import fsyn_pkg::*;

  localparam int RW = $clog2(REF_DIV + 1);
  localparam logic [RW-1:0] REF_RATIO = RW'(REF_DIV);

  logic [NW-1:0] vco_ratio;
  logic ref_div, ref_fall, vco_div, vco_fall, up, dn;

  assign vco_ratio = {1'b1, n_word[NW-2:0]};

  fsyn_div #(.W(RW)) u_ref (
    .clk(clk), .rst(rst), .sig_in(xtal_in), .ratio(REF_RATIO),
    .div_o(ref_div), .fall_o(ref_fall)
  );

  fsyn_div #(.W(NW)) u_vco (
    .clk(clk), .rst(rst), .sig_in(vco_in), .ratio(vco_ratio),
    .div_o(vco_div), .fall_o(vco_fall)
  );

  fsyn_pfd u_pfd (
    .clk(clk), .rst(rst), .ref_fall(ref_fall), .vco_fall(vco_fall),
    .up_o(up), .dn_o(dn)
  );

  assign cur_hi = boost;

  always_comb begin
    up_en   = 1'b0;
    dn_en   = 1'b0;
    pin_oe  = 1'b0;
    pin_val = 1'b0;
    amp_oe  = 1'b1;
    case (tmode)
      TM_REF: begin
        pin_oe  = 1'b1;
        pin_val = ref_div;
      end
      TM_VCO: begin
        pin_oe  = 1'b1;
        pin_val = vco_div;
      end
      TM_PD_Z:  ;
      TM_ALL_Z: amp_oe = 1'b0;
      default: begin
        up_en   = up;
        dn_en   = dn;
        pin_oe  = up | dn;
        pin_val = up;
      end
    endcase
  end

  AST_PIN_FOLLOWS_PFD: assert property (@(posedge clk) disable iff (rst)
    (tmode == 3'b000) |-> (pin_oe == (up_en ^ dn_en))); // R10
endmodule

// File: tb/fsyn_core_test.sv
`timescale 1ns/1ps
module fsyn_core_test;
  localparam int RD = 5;
  localparam int W  = 4;

  logic clk = 1'b0, rst = 1'b1, xtal_in = 1'b0, vco_in = 1'b0;
  logic [W-1:0] n_word = '0;
  logic boost = 1'b0;
  logic [2:0] tmode = 3'b000;
  logic up_en, dn_en, cur_hi, pin_oe, pin_val, amp_oe;

  int n_cmp = 0, n_bad = 0;
  int pr = 4, pv = 2, ph_x = 0, ph_v = 0;
  bit x_run = 0, v_run = 0, done = 0;

  always #10 clk = ~clk;

  fsyn_core #(.REF_DIV(RD), .NW(W)) uut (
    .clk(clk), .rst(rst), .xtal_in(xtal_in), .vco_in(vco_in),
    .n_word(n_word), .boost(boost), .tmode(tmode),
    .up_en(up_en), .dn_en(dn_en), .cur_hi(cur_hi),
    .pin_oe(pin_oe), .pin_val(pin_val), .amp_oe(amp_oe)
  );

  always @(negedge clk) begin
    if (x_run) begin
      xtal_in = (ph_x < pr / 2);
      ph_x = (ph_x == pr - 1) ? 0 : ph_x + 1;
    end else begin
      xtal_in = 1'b0; ph_x = 0;
    end
    if (v_run) begin
      vco_in = (ph_v < pv / 2);
      ph_v = (ph_v == pv - 1) ? 0 : ph_v + 1;
    end else begin
      vco_in = 1'b0; ph_v = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk);
    x_run = 0; v_run = 0; rst = 1'b1;
    repeat (4) @(posedge clk);
    rst = 1'b0;
  endtask

  task automatic start(input bit sx, input bit sv);
    @(posedge clk);
    x_run = sx; v_run = sv;
  endtask

  task automatic wait_fall(output realtime t);
    logic prev;
    @(negedge clk);
    prev = pin_val;
    forever begin
      @(negedge clk);
      if (prev && !pin_val) break;
      prev = pin_val;
    end
    t = $realtime;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    realtime t0, t1, t2, t3;
    int cnt_oe, cnt_up, cnt_dn, amp_low;

    // R1: reset state
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!up_en && !dn_en && !pin_oe && amp_oe, "R1 reset outputs",
        {up_en, dn_en, pin_oe, amp_oe}, 4'b0001);
    rst = 1'b0;

    // R3 R4 R5 R6 R8: sweep every ratio word at two VCO periods
    for (int p = 2; p <= 4; p += 2) begin
      for (int n = 0; n < 16; n++) begin
        int nn, tv, tr, diff, win, eu, ed;
        n_word = n[W-1:0]; boost = n[0]; tmode = 3'b000; pr = 4; pv = p;
        do_reset();
        nn = 8 + (n % 8);
        tv = (nn - 1) * p;
        tr = (RD - 1) * pr;
        diff = tr - tv;
        win = ((tv > tr) ? tv : tr) + 6;
        eu = (diff > 0) ? diff : 0;
        ed = (diff < 0) ? -diff : 0;
        start(1, 1);
        cnt_up = 0; cnt_dn = 0; cnt_oe = 0;
        for (int c = 0; c < win; c++) begin
          @(negedge clk);
          cnt_up += int'(up_en);
          cnt_dn += int'(dn_en);
          cnt_oe += int'(pin_oe);
        end
        if (diff > 0) begin
          chk(cnt_up == eu, "R3 up width (R6 ratio)", cnt_up, eu);
          chk(cnt_dn == 0, "R3 no down", cnt_dn, 0);
        end else if (diff < 0) begin
          chk(cnt_dn == ed, "R4 down width (R6 ratio)", cnt_dn, ed);
          chk(cnt_up == 0, "R4 no up", cnt_up, 0);
        end else begin
          chk(cnt_up == 0 && cnt_dn == 0, "R5 coincident edges", cnt_up + cnt_dn, 0);
          chk(cnt_oe == 0, "R5 pin undriven", cnt_oe, 0);
        end
        chk(cur_hi == boost, "R8 current select", int'(cur_hi), int'(boost));
      end
    end

    // R2 R9: divided reference on the detector pin
    tmode = 3'b100; pr = 4;
    do_reset();
    start(1, 0);
    wait_fall(t0);
    wait_fall(t1);
    chk(int'((t1 - t0) / 20.0) == RD * pr, "R2 reference period",
        int'((t1 - t0) / 20.0), RD * pr);
    chk(pin_oe && !up_en && !dn_en, "R9 ref test code", {pin_oe, up_en, dn_en}, 3'b100);

    // R9 R7: divided VCO on the pin, ratio change mid-period
    tmode = 3'b110; pv = 2; n_word = 4'd1;
    do_reset();
    start(0, 1);
    wait_fall(t0);
    wait_fall(t1);
    chk(int'((t1 - t0) / 20.0) == 9 * pv, "R9 vco period",
        int'((t1 - t0) / 20.0), 9 * pv);
    chk(pin_oe && !up_en && !dn_en, "R9 vco test code", {pin_oe, up_en, dn_en}, 3'b100);
    repeat (3) @(negedge clk);
    n_word = 4'd5;
    wait_fall(t2);
    wait_fall(t3);
    chk(int'((t2 - t1) / 20.0) == 9 * pv, "R7 old ratio kept",
        int'((t2 - t1) / 20.0), 9 * pv);
    chk(int'((t3 - t2) / 20.0) == 13 * pv, "R7 new ratio applied",
        int'((t3 - t2) / 20.0), 13 * pv);

    // R10: tri-state codes and an unlisted code
    for (int k = 0; k < 3; k++) begin
      tmode = (k == 0) ? 3'b111 : (k == 1) ? 3'b011 : 3'b001;
      n_word = 4'd0; pr = 4; pv = 2;
      do_reset();
      start(1, 1);
      cnt_oe = 0; cnt_up = 0; amp_low = 0;
      for (int c = 0; c < 22; c++) begin
        @(negedge clk);
        cnt_oe += int'(pin_oe);
        cnt_up += int'(up_en) + int'(dn_en);
        amp_low += int'(!amp_oe);
      end
      if (k == 0) begin
        chk(cnt_oe == 0 && cnt_up == 0, "R10 code 111 pin off", cnt_oe + cnt_up, 0);
        chk(amp_low == 0, "R10 code 111 amp on", amp_low, 0);
      end else if (k == 1) begin
        chk(cnt_oe == 0 && cnt_up == 0, "R10 code 011 pin off", cnt_oe + cnt_up, 0);
        chk(amp_low == 22, "R10 code 011 amp off", amp_low, 22);
      end else begin
        chk(cnt_oe == 2 && cnt_up == 2, "R10 code 001 acts normal", cnt_oe, 2);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule